// File: doc/BRIEF.md
# Serial Address Recognition Filter

This block sits behind a UART receiver and decides, for every received byte, whether the receive flag gets set. It holds three 8-bit registers: a control register, a slave address register and an address mask register. Software writes and reads them through a small address/data port.

When the control register selects a nonzero serial mode and enables multiprocessor operation, the filter is active. While it is active, a received byte is accepted only if it matches the masked slave address, or if it carries every bit of a broadcast pattern. The broadcast pattern is derived as the address ORed with the mask. A byte that matches neither is dropped silently. When the filter is not active, every received byte is accepted.

An accepted byte sets a sticky receive flag in the control register and raises a one-cycle set pulse. Software clears the flag by writing zero to it.

Top module: `uart_addr_filter`

## Requirements
- R1: After reset, the control, address and mask registers read 0x00, `rx_flag` is low and `rx_flag_set` is low.
- R2: A write with `wr_en` high stores `wr_data` in the selected register: `reg_sel` 0 selects control, 1 selects address and 2 selects mask. `rd_data` returns the current value of the register that `reg_sel` selects, and select 3 reads 0x00. A register that is not selected by a write keeps its value.
- R3: The filter is active only when control bits [7:6] are nonzero and control bit 5 is 1. In every other case, each `rx_valid` strobe sets the flag.
- R4: While the filter is active, a byte is accepted when (address AND mask) equals (byte AND mask).
- R5: While the filter is active, a byte is accepted when every bit set in (address OR mask) is also set in the byte.
- R6: While the filter is active, a byte that satisfies neither R4 nor R5 leaves `rx_flag` unchanged and raises no set pulse.
- R7: With the mask at 0x00, every received byte is accepted in any mode.
- R8: The receive flag is control bit 0. It stays set until software writes 0 to it. If an accepted byte arrives in the same cycle as that write, the byte wins and the flag is set.
- R9: `rx_flag_set` is high for exactly the one cycle after the clock edge that captures an accepted `rx_valid` strobe. `rx_flag` is high from that same cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 = control, 1 = address, 2 = mask |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Readback of the selected register |
| rx_valid | input | 1 | Single-cycle strobe for a received byte |
| rx_byte | input | 8 | Received data byte |
| rx_flag | output | 1 | Sticky receive flag (control bit 0) |
| rx_flag_set | output | 1 | One-cycle pulse when a byte is accepted |

## Verification
The bench builds the block with its default 8-bit data width and 2-bit register select. With these values the address/mask pair 0x35/0x0F yields a broadcast pattern of 0x3F. Specific bytes then separate the cases: 0x7F hits only the broadcast rule, 0xA5 hits the individual rule, and 0x06 misses both. Each filter outcome is therefore reached with a byte that no other rule would accept. A mask of 0x00 shows transparency, including for the byte 0x00.

// File: rtl/uart_addr_filter.sv
module uart_addr_filter #(
  parameter int W     = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_byte,
  output logic             rx_flag,
  output logic             rx_flag_set
);
  localparam int MODE_HI = W - 1;
  localparam int MODE_LO = W - 2;
  localparam int MPE_BIT = W - 3;
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ADDR = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_MASK = SEL_W'(2);

  logic [W-1:0] ctrl_q, addr_q, mask_q;
  logic         set_q;

  wire          filt_on = (|ctrl_q[MODE_HI:MODE_LO]) & ctrl_q[MPE_BIT];
  wire [W-1:0]  bcast   = addr_q | mask_q;
  wire          ind_hit = ((addr_q ^ rx_byte) & mask_q) == '0;
  wire          bc_hit  = (rx_byte & bcast) == bcast;
  wire          accept  = rx_valid & (~filt_on | ind_hit | bc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      mask_q <= '0;
      set_q  <= 1'b0;
    end else begin
      if (wr_en && reg_sel == SEL_CTRL) ctrl_q <= wr_data;
      if (wr_en && reg_sel == SEL_ADDR) addr_q <= wr_data;
      if (wr_en && reg_sel == SEL_MASK) mask_q <= wr_data;
      if (accept) ctrl_q[0] <= 1'b1;
      set_q <= accept;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: rd_data = ctrl_q;
      SEL_ADDR: rd_data = addr_q;
      SEL_MASK: rd_data = mask_q;
      default:  rd_data = '0;
    endcase
  end

  assign rx_flag     = ctrl_q[0];
  assign rx_flag_set = set_q;
endmodule

// File: rtl/uart_addr_filter_chk.sv
module uart_addr_filter_chk #(
  parameter int W     = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] reg_sel,
  input logic [W-1:0]     wr_data,
  input logic             rx_valid,
  input logic [W-1:0]     rx_byte,
  input logic             rx_flag,
  input logic             rx_flag_set,
  input logic [W-1:0]     ctrl_q,
  input logic [W-1:0]     addr_q,
  input logic [W-1:0]     mask_q
);
  wire act      = (ctrl_q[W-1:W-2] != 2'b00) && ctrl_q[W-3];
  wire miss_ind = (addr_q & mask_q) != (rx_byte & mask_q);
  wire miss_bc  = (rx_byte & (addr_q | mask_q)) != (addr_q | mask_q);
  wire ctrl_wr  = wr_en && reg_sel == SEL_W'(0);
  wire addr_wr  = wr_en && reg_sel == SEL_W'(1);
  wire mask_wr  = wr_en && reg_sel == SEL_W'(2);

  // R9
  pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !rx_flag_set);
  // R3
  unfiltered_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !act) |=> rx_flag_set);
  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && act && miss_ind && miss_bc) |=> !rx_flag_set);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !rx_valid) |=> $stable(rx_flag));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag_set |-> rx_flag);
  // R7
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mask_q == '0) |=> rx_flag_set);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> $stable(addr_q));
  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wr_data)));
endmodule

bind uart_addr_filter uart_addr_filter_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
  .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_flag(rx_flag),
  .rx_flag_set(rx_flag_set), .ctrl_q(ctrl_q), .addr_q(addr_q), .mask_q(mask_q)
);

// File: tb/test_uart_addr_filter.sv
module test_uart_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_flag, rx_flag_set;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  uart_addr_filter i_uart_addr_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_flag(rx_flag), .rx_flag_set(rx_flag_set)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1 d = rd_data;
  endtask

  // strobe a byte, then sample pulse and flag in the cycle after capture
  task automatic send(input logic [7:0] b, output logic p, output logic f);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0; p = rx_flag_set; f = rx_flag;
  endtask

  task automatic clr_flag(input logic [7:0] ctrl);
    wr(2'd0, ctrl & 8'hFE);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 addr", v, 8'h00);
    rd(2'd2, v); chk("R1 mask", v, 8'h00);
    chk("R1 flag", rx_flag, 0); chk("R1 pulse", rx_flag_set, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd1, 8'h35); wr(2'd2, 8'h0F); wr(2'd0, 8'hA0);
    rd(2'd1, v); chk("R2 addr", v, 8'h35);
    rd(2'd2, v); chk("R2 mask", v, 8'h0F);
    rd(2'd0, v); chk("R2 ctrl", v, 8'hA0);
    rd(2'd3, v); chk("R2 sel3", v, 8'h00);
    wr(2'd3, 8'hFF);
    rd(2'd1, v); chk("R2 addr kept", v, 8'h35);
  endtask

  task automatic t_filter;
    logic p, f;
    send(8'hA5, p, f); chk("R4 ind pulse", p, 1); chk("R4 ind flag", f, 1);
    @(negedge clk); chk("R9 pulse one cycle", rx_flag_set, 0);
    clr_flag(8'hA0); chk("R8 cleared", rx_flag, 0);
    send(8'h7F, p, f); chk("R5 bcast pulse", p, 1); chk("R5 bcast flag", f, 1);
    clr_flag(8'hA0);
    send(8'h06, p, f); chk("R6 drop pulse", p, 0); chk("R6 drop flag", f, 0);
    send(8'hC5, p, f); chk("R4 ind C5", p, 1);
    clr_flag(8'hA0);
  endtask

  task automatic t_unfiltered;
    logic p, f;
    wr(2'd0, 8'h20);
    send(8'h06, p, f); chk("R3 mode0 pulse", p, 1); chk("R3 mode0 flag", f, 1);
    clr_flag(8'h20);
    wr(2'd0, 8'h80);
    send(8'h06, p, f); chk("R3 mpe0 pulse", p, 1);
    clr_flag(8'h80);
  endtask

  task automatic t_mask_zero;
    logic p, f;
    wr(2'd0, 8'hE0); wr(2'd2, 8'h00);
    send(8'h00, p, f); chk("R7 byte00", p, 1);
    clr_flag(8'hE0);
    send(8'h9A, p, f); chk("R7 byte9A", p, 1);
    clr_flag(8'hE0);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_sticky;
    logic p, f;
    wr(2'd0, 8'hA0);
    send(8'hA5, p, f);
    repeat (3) @(negedge clk);
    chk("R8 sticky", rx_flag, 1);
    send(8'h06, p, f); chk("R8 drop keeps flag", f, 1); chk("R6 no pulse", p, 0);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd0; wr_data = 8'hA0; rx_valid = 1'b1; rx_byte = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    chk("R8 set wins", rx_flag, 1); chk("R9 pulse", rx_flag_set, 1);
    clr_flag(8'hA0); chk("R8 clear", rx_flag, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_filter;
    t_unfiltered;
    t_mask_zero;
    t_sticky;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule